// File: doc/BRIEF.md
# Indirect Serial Register Window Bridge

This bridge gives a host processor access to a bank of error-reporting registers that sit behind a slow, one-bit-wide internal serial link. The host never waits on the link. To read, it writes a selector register with a controller number, a register offset and a start bit. The bridge then shifts a request frame out and collects the 32-bit reply. When the reply is complete it raises a completion flag. After that, an ordinary host read of the same offset inside the register window returns the fetched word.

A host write inside the window is posted. The host cycle finishes at once, and the bridge ships the word as a serial write frame that completes some time later.

Every transaction has a watchdog on its wait-for-responder phase. If the watchdog expires, the transaction is abandoned, the error is recorded in a sticky flag, and an abandoned read completes with zero data. One request that arrives while the link is busy is held back and issued when the link becomes free.

Top module: `sbus_window_bridge`

## Requirements
- R1: After reset, the selector register (offset 0x04) reads 0, the control register (offset 0x08) reads 1, `timeout_flag` is 0 and `sb_sel` is 0.
- R2: The selector register holds the controller number in bits 10:0, the register offset in bits 23:16, the start bit in bit 15 and the completion flag in bit 24. The start bit and every other bit always read back as 0.
- R3: A write of 1 to the start bit launches a read frame on the next clock. While `sb_sel` is high, `sb_dout` carries one bit per clock, most significant bit first, for 20 clocks: a command bit of 0, then the 11-bit controller number, then the 8-bit offset.
- R4: A host write to offsets 0x10–0x3B is posted, and its frame starts on the next clock. The frame is 52 bits: a command bit of 1, the controller number held in the selector register, the 8-bit offset, then the 32-bit data. A single `sb_ack` pulse completes it.
- R5: A start-bit write clears the completion flag. The flag sets once 32 reply bits have been sampled from `sb_din`, one per clock after the `sb_ack` clock, most significant bit first. From then on, a window read at the fetched offset returns that word, and window reads at any other offset return 0.
- R6: A window read made while a transaction is in flight returns the previously latched word.
- R7: A read start or window write that arrives during a transaction is held in a single slot and issued after the current transaction, in arrival order. A request that arrives while the slot is already occupied is discarded.
- R8: With the watchdog enabled, a transaction that receives no `sb_ack` within `TMO_CYC` clocks of waiting is aborted and `timeout_flag` is set. An aborted read sets the completion flag and latches zero data. An `sb_ack` in the last allowed clock still completes normally, and an `sb_ack` that arrives after an abort has no effect.
- R9: Control register bit 0 enables the watchdog (reset value 1). When it is 0, a transaction waits for `sb_ack` without limit.
- R10: At offset 0x0C, writing 1 to bit 1 sets `timeout_flag` and writing 1 to bit 9 clears it. If both are written together, set wins. The register always reads 0.
- R11: The controller number is sent unchanged even when it is not 0 (a reserved value). When no responder answers such a read, it ends through the watchdog with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Host write strobe, one clock per write |
| cpu_addr | input | 8 | Host byte offset |
| cpu_wdata | input | 32 | Host write data |
| cpu_rdata | output | 32 | Host read data, combinational from `cpu_addr` |
| sb_sel | output | 1 | High while a frame bit is being driven |
| sb_dout | output | 1 | Serial frame data toward the responder |
| sb_ack | input | 1 | Responder acknowledge pulse |
| sb_din | input | 1 | Serial reply data from the responder |
| timeout_flag | output | 1 | Sticky watchdog error flag |

## Verification
Two events can land on the same clock edge, and each is forced deliberately. The first pair is a responder acknowledge and watchdog expiry: the reply is delayed by exactly 63 and then 64 waiting clocks, and the bench expects real data in the first case and zero data with the flag set in the second. The second pair is a software set and a software clear of the error flag, written in one host write; the flag must end up set. A near-exhaustive sweep reads every window offset with responder latencies that vary from read to read, and compares each result with a pattern computed from the offset.

// File: rtl/sbus_window_bridge.sv
module sbus_window_bridge #(
  parameter int TMO_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [7:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        sb_sel,
  output logic        sb_dout,
  input  logic        sb_ack,
  input  logic        sb_din,
  output logic        timeout_flag
);
  localparam int IDW = 11;
  localparam int OFW = 8;
  localparam int DW  = 32;
  localparam int HDR = 1 + IDW + OFW;
  localparam int FRM = HDR + DW;
  localparam int BW  = $clog2(FRM);
  localparam int RW  = $clog2(DW);
  localparam int TW  = $clog2(TMO_CYC + 1);
  localparam logic [7:0] A_SEL = 8'h04;
  localparam logic [7:0] A_CTL = 8'h08;
  localparam logic [7:0] A_TST = 8'h0C;
  localparam logic [7:0] W_LO  = 8'h10;
  localparam logic [7:0] W_HI  = 8'h3B;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_t;
  st_t st;

  logic [IDW-1:0] sel_id;
  logic [OFW-1:0] sel_off;
  logic           done, tmo_en;
  logic [FRM-1:0] shreg;
  logic [BW-1:0]  bitcnt;
  logic [RW-1:0]  rcnt;
  logic [TW-1:0]  tmo_cnt;
  logic [DW-1:0]  rxsh, rdat;
  logic [OFW-1:0] rdat_off, cur_off;
  logic           cur_wr;
  logic           p_v, p_wr;
  logic [IDW-1:0] p_id;
  logic [OFW-1:0] p_off;
  logic [DW-1:0]  p_dat;

  wire in_win   = (cpu_addr >= W_LO) && (cpu_addr <= W_HI);
  wire trig_req = cpu_we && (cpu_addr == A_SEL) && cpu_wdata[15];
  wire wr_req   = cpu_we && in_win;
  wire req      = trig_req || wr_req;
  wire [IDW-1:0] req_id  = trig_req ? cpu_wdata[10:0] : sel_id;
  wire [OFW-1:0] req_off = trig_req ? cpu_wdata[23:16] : cpu_addr;
  wire tst_wr   = cpu_we && (cpu_addr == A_TST);
  wire busy     = (st != S_IDLE);
  wire launch   = !busy && (p_v || req);
  wire           l_wr  = p_v ? p_wr  : wr_req;
  wire [IDW-1:0] l_id  = p_v ? p_id  : req_id;
  wire [OFW-1:0] l_off = p_v ? p_off : req_off;
  wire [DW-1:0]  l_dat = p_v ? p_dat : cpu_wdata;
  wire tmo_hit  = (st == S_WAIT) && !sb_ack && tmo_en && (tmo_cnt >= TW'(TMO_CYC - 1));
  wire rd_end   = (st == S_RECV) && (rcnt == '0);

  assign sb_sel  = (st == S_SEND);
  assign sb_dout = sb_sel & shreg[FRM-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_id <= '0; sel_off <= '0; tmo_en <= 1'b1; timeout_flag <= 1'b0;
      done <= 1'b0; rdat <= '0; rdat_off <= '0;
      p_v <= 1'b0; p_wr <= 1'b0; p_id <= '0; p_off <= '0; p_dat <= '0;
    end else begin
      if (cpu_we && cpu_addr == A_SEL) begin
        sel_id  <= cpu_wdata[10:0];
        sel_off <= cpu_wdata[23:16];
      end
      if (cpu_we && cpu_addr == A_CTL) tmo_en <= cpu_wdata[0];
      if (tmo_hit || (tst_wr && cpu_wdata[1])) timeout_flag <= 1'b1;
      else if (tst_wr && cpu_wdata[9])         timeout_flag <= 1'b0;
      if (trig_req) done <= 1'b0;
      else if (rd_end || (tmo_hit && !cur_wr)) done <= 1'b1;
      if (rd_end) begin
        rdat     <= {rxsh[DW-2:0], sb_din};
        rdat_off <= cur_off;
      end else if (tmo_hit && !cur_wr) begin
        rdat     <= '0;
        rdat_off <= cur_off;
      end
      if ((launch && p_v) || (!launch && req && !p_v)) begin
        p_v   <= req;
        p_wr  <= wr_req;
        p_id  <= req_id;
        p_off <= req_off;
        p_dat <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; bitcnt <= '0; rcnt <= '0;
      tmo_cnt <= '0; rxsh <= '0; cur_wr <= 1'b0; cur_off <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          st      <= S_SEND;
          shreg   <= {l_wr, l_id, l_off, l_dat};
          bitcnt  <= l_wr ? BW'(FRM - 1) : BW'(HDR - 1);
          cur_wr  <= l_wr;
          cur_off <= l_off;
        end
        S_SEND: begin
          shreg <= shreg << 1;
          if (bitcnt == '0) begin
            st      <= S_WAIT;
            tmo_cnt <= '0;
          end else bitcnt <= bitcnt - 1'b1;
        end
        S_WAIT: begin
          if (sb_ack) begin
            st   <= cur_wr ? S_IDLE : S_RECV;
            rcnt <= RW'(DW - 1);
          end else if (tmo_hit) st <= S_IDLE;
          else if (tmo_cnt < TW'(TMO_CYC - 1)) tmo_cnt <= tmo_cnt + 1'b1;
        end
        S_RECV: begin
          rxsh <= {rxsh[DW-2:0], sb_din};
          if (rcnt == '0) st <= S_IDLE;
          else rcnt <= rcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == A_SEL)       cpu_rdata = {7'd0, done, sel_off, 1'b0, 4'd0, sel_id};
    else if (cpu_addr == A_CTL)  cpu_rdata = {31'd0, tmo_en};
    else if (in_win && cpu_addr == rdat_off) cpu_rdata = rdat;
  end

  // R5
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |=> !done);

  // R5
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st == S_RECV) || $past(st == S_WAIT)));

  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> ($past(st == S_WAIT) || $past(tst_wr && cpu_wdata[1])));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && !p_v) |=> p_v);

  // R9
  no_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !tmo_en && !sb_ack) |=> (st == S_WAIT));
endmodule

// File: tb/sbus_window_bridge_test.sv
module sbus_window_bridge_test;
  logic clk = 0, rst_n = 0;
  logic cpu_we = 0;
  logic [7:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic [31:0] cpu_rdata;
  logic sb_sel, sb_dout, timeout_flag;
  logic sb_ack = 0, sb_din = 0;

  int checks = 0, errors = 0;
  int rsp_lat = 2;
  logic [31:0] mem [0:255];
  logic [31:0] expm [0:255];
  logic [51:0] hdr;
  int nb, last_nb;
  logic last_cmd;
  logic [10:0] last_id;
  logic [7:0] last_off;
  logic [31:0] last_dat;

  always #10 clk = ~clk;

  sbus_window_bridge #(.TMO_CYC(64)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sb_sel(sb_sel),
    .sb_dout(sb_dout), .sb_ack(sb_ack), .sb_din(sb_din),
    .timeout_flag(timeout_flag));

  function automatic logic [31:0] pat(input int a);
    logic [31:0] x;
    x = 32'h9E3779B1 * (a + 3);
    return x ^ (a << 24);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = pat(i); expm[i] = pat(i); end
    forever begin
      hdr = '0; nb = 0;
      do @(negedge clk); while (!sb_sel);
      while (sb_sel) begin
        hdr = {hdr[50:0], sb_dout};
        nb++;
        @(negedge clk);
      end
      last_nb = nb;
      if (nb == 52) begin
        last_cmd = hdr[51]; last_id = hdr[50:40]; last_off = hdr[39:32]; last_dat = hdr[31:0];
      end else begin
        last_cmd = hdr[19]; last_id = hdr[18:8]; last_off = hdr[7:0]; last_dat = '0;
      end
      if (last_id == 0) begin
        repeat (rsp_lat) @(negedge clk);
        sb_ack = 1;
        @(negedge clk);
        sb_ack = 0;
        if (last_cmd) mem[last_off] = last_dat;
        else begin
          for (int i = 31; i >= 0; i--) begin
            sb_din = mem[last_off][i];
            @(negedge clk);
          end
          sb_din = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    cpu_addr = a;
    #1 v = cpu_rdata;
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 0;
    for (int n = 0; n < 600 && !seen; n++) begin
      @(negedge clk);
      cpu_addr = 8'h04;
      #1 seen = cpu_rdata[24];
    end
    chk(tag, {31'd0, seen}, 32'd1);
  endtask

  task automatic trig(input logic [10:0] id, input logic [7:0] off);
    wr(8'h04, {8'd0, off, 1'b1, 4'd0, id});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(8'h04, v); chk("R1 selector", v, 32'h0);
    rd(8'h08, v); chk("R1 control", v, 32'h1);
    chk("R1 flag", {31'd0, timeout_flag}, 32'h0);
    chk("R1 sel", {31'd0, sb_sel}, 32'h0);
    // R2
    wr(8'h04, 32'hFEFF7FFF);
    rd(8'h04, v); chk("R2 layout", v, 32'h00FF07FF);
    wr(8'h04, 32'h00AB8000);
    rd(8'h04, v); chk("R2 start reads 0", v, 32'h00AB0000);
    wait_done("R2 done");
    // R3 frame
    rsp_lat = 1;
    trig(11'd0, 8'h2C);
    wait_done("R3 done");
    chk("R3 length", last_nb, 20);
    chk("R3 cmd", {31'd0, last_cmd}, 32'd0);
    chk("R3 offset", {24'd0, last_off}, 32'h2C);
    rd(8'h2C, v); chk("R5 data 0x2C", v, expm[8'h2C]);
    rd(8'h30, v); chk("R5 other offset", v, 32'h0);
    // R5 sweep
    for (int a = 8'h10; a <= 8'h3B; a++) begin
      rsp_lat = a % 7;
      trig(11'd0, a[7:0]);
      rd(8'h04, v); chk("R5 done cleared", {31'd0, v[24]}, 32'd0);
      wait_done("R5 sweep done");
      rd(a[7:0], v); chk("R5 sweep data", v, expm[a]);
    end
    // R4 posted write
    rsp_lat = 2;
    wr(8'h12, 32'h12345678);
    chk("R4 starts next clock", {31'd0, sb_sel}, 32'd1);
    expm[8'h12] = 32'h12345678;
    repeat (70) @(negedge clk);
    chk("R4 length", last_nb, 52);
    chk("R4 cmd", {31'd0, last_cmd}, 32'd1);
    chk("R4 offset", {24'd0, last_off}, 32'h12);
    chk("R4 data", last_dat, 32'h12345678);
    chk("R4 id", {21'd0, last_id}, 32'd0);
    // R6
    trig(11'd0, 8'h20); wait_done("R6 first");
    wr(8'h20, 32'hCAFEF00D); expm[8'h20] = 32'hCAFEF00D;
    repeat (70) @(negedge clk);
    rsp_lat = 30;
    trig(11'd0, 8'h20);
    repeat (10) @(negedge clk);
    rd(8'h20, v); chk("R6 old while busy", v, pat(8'h20));
    wait_done("R6 second");
    rd(8'h20, v); chk("R6 new after done", v, 32'hCAFEF00D);
    // R7
    rsp_lat = 2;
    wr(8'h30, 32'hA0A0A0A0); expm[8'h30] = 32'hA0A0A0A0;
    wr(8'h34, 32'hB1B1B1B1); expm[8'h34] = 32'hB1B1B1B1;
    wr(8'h38, 32'hC2C2C2C2);
    repeat (250) @(negedge clk);
    trig(11'd0, 8'h38); wait_done("R7 dropped done");
    rd(8'h38, v); chk("R7 third dropped", v, expm[8'h38]);
    trig(11'd0, 8'h34); wait_done("R7 held done");
    rd(8'h34, v); chk("R7 held write", v, 32'hB1B1B1B1);
    wr(8'h3A, 32'hD3D3D3D3); expm[8'h3A] = 32'hD3D3D3D3;
    trig(11'd0, 8'h3A); wait_done("R7 order done");
    rd(8'h3A, v); chk("R7 order", v, 32'hD3D3D3D3);
    // R8
    rsp_lat = 63;
    trig(11'd0, 8'h18); wait_done("R8 ack last clock");
    rd(8'h18, v); chk("R8 ack wins", v, expm[8'h18]);
    chk("R8 no flag", {31'd0, timeout_flag}, 32'd0);
    rsp_lat = 64;
    trig(11'd0, 8'h1C); wait_done("R8 expiry done");
    rd(8'h1C, v); chk("R8 zero data", v, 32'h0);
    chk("R8 flag set", {31'd0, timeout_flag}, 32'd1);
    repeat (45) @(negedge clk);
    rd(8'h1C, v); chk("R8 late ack ignored", v, 32'h0);
    wr(8'h0C, 32'h200);
    chk("R10 clear", {31'd0, timeout_flag}, 32'd0);
    // R11
    trig(11'd5, 8'h24); wait_done("R11 done");
    chk("R11 id sent", {21'd0, last_id}, 32'd5);
    rd(8'h24, v); chk("R11 zero data", v, 32'h0);
    chk("R11 flag", {31'd0, timeout_flag}, 32'd1);
    wr(8'h0C, 32'h200);
    // R9
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R9 control", v, 32'h0);
    rsp_lat = 100;
    trig(11'd0, 8'h28); wait_done("R9 done");
    rd(8'h28, v); chk("R9 long wait data", v, expm[8'h28]);
    chk("R9 no flag", {31'd0, timeout_flag}, 32'd0);
    wr(8'h08, 32'h1);
    // R10
    wr(8'h0C, 32'h2);
    chk("R10 set", {31'd0, timeout_flag}, 32'd1);
    rd(8'h0C, v); chk("R10 reads 0", v, 32'h0);
    wr(8'h0C, 32'h200);
    chk("R10 clear", {31'd0, timeout_flag}, 32'd0);
    wr(8'h0C, 32'h202);
    chk("R10 set wins", {31'd0, timeout_flag}, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule